// File: doc/BRIEF.md
# Step-Driven Accumulator Processor

This block is a tiny processor that an operator drives one step at a time. A single 8-bit input bus carries both operands and instruction codes. Each single-cycle step pulse stores the bus into the next internal register in a fixed four-phase cycle: first operand A, then operand B, then the operation code. The fourth pulse runs the selected arithmetic/logic function and then the selected shift. It stores the 8-bit outcome in a result register and a ninth bit in a carry flip-flop. The phase output tells the operator which entry the next pulse will take.

The operation code chooses an ALU function and where the ALU carry input comes from (the stored carry or a constant one). It also chooses a shifter function and whether the next operand A is taken from the bus or from the current result. That last choice lets results be chained without being typed in again. Because A is loaded before the new operation code, the source choice comes from the operation code that is already latched.

Top module: `manual_step_proc`

## Requirements
- R1: While `rst` is high at a rising clock edge, phase, result, carry and all internal registers (A, B, operation code) are cleared to zero.
- R2: Phase encoding is 0 = take A, 1 = take B, 2 = take operation code, 3 = execute. Each step pulse advances the phase by one, wrapping from 3 to 0. With no step pulse the phase holds.
- R3: A step pulse in a cycle where `rst` is high is ignored: phase, result and carry are zero after reset, and the next pulse takes A.
- R4: Arithmetic ALU codes in opcode bits [2:0] are 001 = B − A, 010 = A − B and 011 = A + B. Subtraction adds the inverted subtrahend plus carry-in. The ALU carry is bit 8 of the 9-bit sum (1 means no borrow).
- R5: Non-arithmetic ALU codes are 000 = all zeros, 100 = A XOR B, 101 = A OR B, 110 = A AND B and 111 = all ones. Each of them gives an ALU carry of 0.
- R6: Opcode bit [3] selects the ALU carry-in: 0 uses the stored carry flip-flop and 1 forces a one.
- R7: Shifter codes in opcode bits [6:4] are 000/110/111 = pass, 001 = left with 0 fill, 010 = left with ALU-carry fill, 011 = logical right, 100 = arithmetic right (sign kept) and 101 = right with ALU-carry fill.
- R8: For a pass the carry flip-flop takes the ALU carry. For any shift it takes the bit shifted out: bit 7 for a left shift, bit 0 for a right shift.
- R9: When bit [7] of the latched operation code is 1, the next take-A step loads A from the result register and ignores the bus. When it is 0, A loads from the bus.
- R10: Result and carry change only on a step pulse in the execute phase. Steps in the other phases leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stepPulse | input | 1 | One-cycle step strobe |
| busIn | input | 8 | Shared data/instruction bus |
| resultOut | output | 8 | Result register |
| carryOut | output | 1 | Carry flip-flop |
| phaseOut | output | 2 | Phase that the next step will perform |

## Verification
The bench chains operations so that the stored carry feeds later ones. A design that ignored the carry-select bit, or cleared the carry between operations, would be off by one on the A + B + C case. Subtraction is run on both the borrow and no-borrow sides, and the 9-bit average (an add followed by a right shift that pulls in the ALU carry) exposes a shifter that fills with zero or takes the wrong carry-out. A chained run checks that A comes from the result only when the previously latched opcode asks for it. Further checks look for a result or carry that moves on a non-execute step, and for a step pulse during reset that gets through and leaves the phase out of order.

// File: rtl/step_proc_pkg.sv
package step_proc_pkg;

  typedef enum logic [1:0] {
    PH_TAKE_A  = 2'd0,
    PH_TAKE_B  = 2'd1,
    PH_TAKE_OP = 2'd2,
    PH_EXEC    = 2'd3
  } phase_e;

  typedef struct packed {
    logic takeA;
    logic takeB;
    logic takeOp;
    logic exec;
  } strobe_t;

  // opcode field positions (decoded by the datapath)
  localparam int OP_ALU_LO  = 0;
  localparam int OP_ALU_W   = 3;
  localparam int OP_CSEL    = 3;
  localparam int OP_SH_LO   = 4;
  localparam int OP_SH_W    = 3;
  localparam int OP_ASRC    = 7;
  localparam int OP_MIN_W   = 8;

  localparam logic [2:0] ALU_ZERO = 3'b000;
  localparam logic [2:0] ALU_BMA  = 3'b001;
  localparam logic [2:0] ALU_AMB  = 3'b010;
  localparam logic [2:0] ALU_ADD  = 3'b011;
  localparam logic [2:0] ALU_XOR  = 3'b100;
  localparam logic [2:0] ALU_OR   = 3'b101;
  localparam logic [2:0] ALU_AND  = 3'b110;
  localparam logic [2:0] ALU_ONES = 3'b111;

  localparam logic [2:0] SH_PASS  = 3'b000;
  localparam logic [2:0] SH_SL0   = 3'b001;
  localparam logic [2:0] SH_SLC   = 3'b010;
  localparam logic [2:0] SH_LSR   = 3'b011;
  localparam logic [2:0] SH_ASR   = 3'b100;
  localparam logic [2:0] SH_SRC   = 3'b101;

endpackage

// File: rtl/step_proc_alu.sv
module step_proc_alu
  import step_proc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [2:0]        fn,
  input  logic              carryIn,
  output logic [DATA_W-1:0] aluVal,
  output logic              aluCarry
);

  localparam int SUM_W = DATA_W + 1;

  logic [SUM_W-1:0] sumAdd;
  logic [SUM_W-1:0] sumAmB;
  logic [SUM_W-1:0] sumBmA;
  logic [SUM_W-1:0] cinExt;

  always_comb begin
    cinExt = {{DATA_W{1'b0}}, carryIn};
    sumAdd = {1'b0, opA} + {1'b0, opB} + cinExt;
    sumAmB = {1'b0, opA} + {1'b0, ~opB} + cinExt;
    sumBmA = {1'b0, opB} + {1'b0, ~opA} + cinExt;
  end

  always_comb begin
    aluCarry = 1'b0;
    aluVal   = '0;
    unique case (fn)
      ALU_ZERO: aluVal = '0;
      ALU_BMA:  {aluCarry, aluVal} = sumBmA;
      ALU_AMB:  {aluCarry, aluVal} = sumAmB;
      ALU_ADD:  {aluCarry, aluVal} = sumAdd;
      ALU_XOR:  aluVal = opA ^ opB;
      ALU_OR:   aluVal = opA | opB;
      ALU_AND:  aluVal = opA & opB;
      ALU_ONES: aluVal = '1;
      default:  aluVal = '0;
    endcase
  end

endmodule

// File: rtl/step_proc_shifter.sv
module step_proc_shifter
  import step_proc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] shIn,
  input  logic              fillCarry,
  input  logic [2:0]        fn,
  output logic [DATA_W-1:0] shOut,
  output logic              carryOutBit
);

  localparam int MSB = DATA_W - 1;

  always_comb begin
    shOut       = shIn;
    carryOutBit = fillCarry;
    unique case (fn)
      SH_SL0: begin
        shOut       = {shIn[MSB-1:0], 1'b0};
        carryOutBit = shIn[MSB];
      end
      SH_SLC: begin
        shOut       = {shIn[MSB-1:0], fillCarry};
        carryOutBit = shIn[MSB];
      end
      SH_LSR: begin
        shOut       = {1'b0, shIn[MSB:1]};
        carryOutBit = shIn[0];
      end
      SH_ASR: begin
        shOut       = {shIn[MSB], shIn[MSB:1]};
        carryOutBit = shIn[0];
      end
      SH_SRC: begin
        shOut       = {fillCarry, shIn[MSB:1]};
        carryOutBit = shIn[0];
      end
      default: begin
        shOut       = shIn;
        carryOutBit = fillCarry;
      end
    endcase
  end

endmodule

// File: rtl/step_proc_ctrl.sv
module step_proc_ctrl
  import step_proc_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    stepPulse,
  output phase_e  phase,
  output strobe_t strobes
);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_TAKE_A;
    end else if (stepPulse) begin
      phase <= phase_e'(phase + 2'd1);
    end
  end

  always_comb begin
    strobes        = '0;
    strobes.takeA  = stepPulse && !rst && (phase == PH_TAKE_A);
    strobes.takeB  = stepPulse && !rst && (phase == PH_TAKE_B);
    strobes.takeOp = stepPulse && !rst && (phase == PH_TAKE_OP);
    strobes.exec   = stepPulse && !rst && (phase == PH_EXEC);
  end

endmodule

// File: rtl/step_proc_datapath.sv
module step_proc_datapath
  import step_proc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strobes,
  input  logic [DATA_W-1:0] busIn,
  output logic [DATA_W-1:0] resultQ,
  output logic              carryQ
);

  logic [DATA_W-1:0] regA;
  logic [DATA_W-1:0] regB;
  logic [DATA_W-1:0] regOp;
  logic [DATA_W-1:0] aSource;
  logic [DATA_W-1:0] aluVal;
  logic              aluCarry;
  logic              aluCin;
  logic [DATA_W-1:0] shVal;
  logic              shCarry;

  // A source picked by the opcode already held
  assign aSource = regOp[OP_ASRC] ? resultQ : busIn;
  assign aluCin  = regOp[OP_CSEL] ? 1'b1 : carryQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      regA    <= '0;
      regB    <= '0;
      regOp   <= '0;
      resultQ <= '0;
      carryQ  <= 1'b0;
    end else begin
      if (strobes.takeA)  regA  <= aSource;
      if (strobes.takeB)  regB  <= busIn;
      if (strobes.takeOp) regOp <= busIn;
      if (strobes.exec) begin
        resultQ <= shVal;
        carryQ  <= shCarry;
      end
    end
  end

  step_proc_alu #(.DATA_W(DATA_W)) u_alu (
    .opA      (regA),
    .opB      (regB),
    .fn       (regOp[OP_ALU_LO +: OP_ALU_W]),
    .carryIn  (aluCin),
    .aluVal   (aluVal),
    .aluCarry (aluCarry)
  );

  step_proc_shifter #(.DATA_W(DATA_W)) u_shift (
    .shIn        (aluVal),
    .fillCarry   (aluCarry),
    .fn          (regOp[OP_SH_LO +: OP_SH_W]),
    .shOut       (shVal),
    .carryOutBit (shCarry)
  );

endmodule

// File: rtl/manual_step_proc.sv
module manual_step_proc
  import step_proc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stepPulse,
  input  logic [DATA_W-1:0] busIn,
  output logic [DATA_W-1:0] resultOut,
  output logic              carryOut,
  output logic [1:0]        phaseOut
);

  phase_e  phase;
  strobe_t strobes;

  step_proc_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .stepPulse (stepPulse),
    .phase     (phase),
    .strobes   (strobes)
  );

  step_proc_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .busIn   (busIn),
    .resultQ (resultOut),
    .carryQ  (carryOut)
  );

  assign phaseOut = phase;

endmodule

// File: rtl/step_proc_checker.sv
module step_proc_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              stepPulse,
  input logic [DATA_W-1:0] resultOut,
  input logic              carryOut,
  input logic [1:0]        phaseOut
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (phaseOut == 2'd0 && resultOut == '0 && carryOut == 1'b0));

  // R2
  phase_step_chk: assert property (@(posedge clk) disable iff (rst)
    stepPulse |=> phaseOut == $past(phaseOut) + 2'd1);

  // R2
  phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !stepPulse |=> $stable(phaseOut));

  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(stepPulse && phaseOut == 2'd3) |=> ($stable(resultOut) && $stable(carryOut)));

endmodule

bind manual_step_proc step_proc_checker #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .stepPulse (stepPulse),
  .resultOut (resultOut),
  .carryOut  (carryOut),
  .phaseOut  (phaseOut)
);

// File: tb/sim_manual_step_proc.sv
`timescale 1ns/1ps
module sim_manual_step_proc;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       stepPulse = 1'b0;
  logic [7:0] busIn = 8'h00;
  logic [7:0] resultOut;
  logic       carryOut;
  logic [1:0] phaseOut;

  int compared = 0;
  int mismatched = 0;
  logic [7:0] expRes;
  logic       expCarry;
  logic       expAsrc;

  always #5 clk = ~clk;

  manual_step_proc u0 (
    .clk       (clk),
    .rst       (rst),
    .stepPulse (stepPulse),
    .busIn     (busIn),
    .resultOut (resultOut),
    .carryOut  (carryOut),
    .phaseOut  (phaseOut)
  );

  task automatic check(input string what, input logic [8:0] act, input logic [8:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  function automatic logic [8:0] model(input logic [7:0] a, input logic [7:0] b,
                                       input logic [7:0] op, input logic cPrev);
    logic       cin;
    logic [8:0] s;
    logic [7:0] v;
    logic       c;
    cin = op[3] ? 1'b1 : cPrev;
    c = 1'b0;
    case (op[2:0])
      3'b001: begin s = {1'b0, b} + {1'b0, ~a} + 9'(cin); {c, v} = s; end
      3'b010: begin s = {1'b0, a} + {1'b0, ~b} + 9'(cin); {c, v} = s; end
      3'b011: begin s = {1'b0, a} + {1'b0, b} + 9'(cin); {c, v} = s; end
      3'b100: v = a ^ b;
      3'b101: v = a | b;
      3'b110: v = a & b;
      3'b111: v = 8'hFF;
      default: v = 8'h00;
    endcase
    case (op[6:4])
      3'b001: return {v[7], v[6:0], 1'b0};
      3'b010: return {v[7], v[6:0], c};
      3'b011: return {v[0], 1'b0, v[7:1]};
      3'b100: return {v[0], v[7], v[7:1]};
      3'b101: return {v[0], c, v[7:1]};
      default: return {c, v};
    endcase
  endfunction

  task automatic pulse(input logic [7:0] d);
    @(negedge clk);
    busIn = d;
    stepPulse = 1'b1;
    @(negedge clk);
    stepPulse = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    stepPulse = 1'b1;
    busIn = 8'h5A;
    @(negedge clk);
    @(negedge clk);
    stepPulse = 1'b0;
    rst = 1'b0;
    expRes = 8'h00;
    expCarry = 1'b0;
    expAsrc = 1'b0;
  endtask

  task automatic runOp(input string tag, input logic [7:0] a, input logic [7:0] b,
                       input logic [7:0] op);
    logic [7:0] effA;
    logic [8:0] e;
    effA = expAsrc ? expRes : a;
    pulse(a);
    pulse(b);
    pulse(op);
    check({tag, " R2 phase before exec"}, {7'd0, phaseOut}, 9'd3);
    pulse(8'h00);
    e = model(effA, b, op, expCarry);
    expCarry = e[8];
    expRes = e[7:0];
    expAsrc = op[7];
    check({tag, " result/carry"}, {carryOut, resultOut}, e);
    check({tag, " R2 phase wraps"}, {7'd0, phaseOut}, 9'd0);
  endtask

  task automatic testReset();
    doReset();
    check("R1 reset result/carry", {carryOut, resultOut}, 9'h000);
    check("R3 step in reset ignored, phase", {7'd0, phaseOut}, 9'd0);
  endtask

  task automatic testPhaseWalk();
    doReset();
    pulse(8'h01);
    check("R2 phase 1", {7'd0, phaseOut}, 9'd1);
    repeat (3) @(negedge clk);
    check("R2 phase holds", {7'd0, phaseOut}, 9'd1);
    pulse(8'h02);
    check("R2 phase 2", {7'd0, phaseOut}, 9'd2);
    pulse(8'h13);
    check("R10 no change before exec", {carryOut, resultOut}, 9'h000);
    pulse(8'h00);
    check("R2 exec wraps to 0", {7'd0, phaseOut}, 9'd0);
    check("R10 exec result", {carryOut, resultOut}, 9'h006);
  endtask

  task automatic testArith();
    doReset();
    runOp("R4 add", 8'h30, 8'h50, 8'h03);
    runOp("R4 add carry out", 8'hF0, 8'h20, 8'h03);
    runOp("R6 stored carry in", 8'h01, 8'h02, 8'h03);
    runOp("R6 forced carry in", 8'h01, 8'h02, 8'h0B);
    runOp("R4 A-B no borrow", 8'h50, 8'h30, 8'h0A);
    runOp("R4 A-B borrow", 8'h30, 8'h50, 8'h0A);
    runOp("R4 B-A", 8'h10, 8'h45, 8'h09);
    check("R4 B-A value", {carryOut, resultOut}, 9'h135);
  endtask

  task automatic testLogic();
    doReset();
    runOp("R5 ones", 8'h12, 8'h34, 8'h07);
    runOp("R5 xor", 8'hF0, 8'h3C, 8'h04);
    runOp("R5 or", 8'hA0, 8'h05, 8'h05);
    runOp("R5 and", 8'hF3, 8'h3F, 8'h06);
    runOp("R5 zero", 8'hFF, 8'hFF, 8'h00);
    check("R5 zero value", {carryOut, resultOut}, 9'h000);
  endtask

  task automatic testShift();
    doReset();
    runOp("R7 sl0", 8'h81, 8'h00, 8'h15);
    check("R8 sl0 out bit", {carryOut, resultOut}, 9'h102);
    runOp("R7 slc", 8'hF0, 8'h20, 8'h23);
    runOp("R7 lsr", 8'h81, 8'h00, 8'h35);
    runOp("R7 asr", 8'h82, 8'h00, 8'h45);
    check("R7 asr value", {carryOut, resultOut}, 9'h0C1);
    runOp("R7 pass 110", 8'h12, 8'h00, 8'h65);
    runOp("R5 clear carry", 8'h00, 8'h00, 8'h00);
    runOp("R7 average", 8'hF0, 8'h20, 8'h53);
    check("R8 average value", {carryOut, resultOut}, 9'h088);
  endtask

  task automatic testChain();
    doReset();
    runOp("R9 set chain", 8'h10, 8'h01, 8'h83);
    runOp("R9 A from result", 8'hAA, 8'h01, 8'h03);
    check("R9 chained value", {carryOut, resultOut}, 9'h012);
    runOp("R9 A from bus again", 8'h40, 8'h01, 8'h03);
    check("R9 bus value", {carryOut, resultOut}, 9'h041);
  endtask

  task automatic testHold();
    doReset();
    runOp("R10 seed", 8'hF0, 8'h20, 8'h03);
    pulse(8'h55);
    check("R10 hold after A", {carryOut, resultOut}, {expCarry, expRes});
    pulse(8'h66);
    check("R10 hold after B", {carryOut, resultOut}, {expCarry, expRes});
    pulse(8'h00);
    check("R10 hold after op", {carryOut, resultOut}, {expCarry, expRes});
    pulse(8'h00);
    check("R10 exec clear", {carryOut, resultOut}, 9'h000);
  endtask

  initial begin
    #1_000_000;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    testPhaseWalk();
    testArith();
    testLogic();
    testShift();
    testChain();
    testHold();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule